// File: doc/BRIEF.md
# Two-Channel Burst PWM Generator

This block drives two independent pulse outputs. Each channel emits a high interval and a low interval, both measured in timebase ticks. It repeats that pair a programmed number of times, or without end. A shared enable mask gives one bit to each channel. Raising a channel's bit starts a fresh pulse train in the high interval. Clearing the bit drops the output at once and rewinds the channel.

The timebase arrives as a single-cycle tick strobe, produced elsewhere from the system clock. Between ticks a channel holds its level. When a finite burst completes, the channel parks its output low and raises its done flag. The flag stays up until the channel is disabled. Software is expected to disable a channel, rewrite its settings and enable it again. The block therefore captures a channel's settings on the cycle it is enabled, and ignores any later changes until the next enable.

Top module: `burst_pwm_pair`

## Requirements
- R1: After reset, every pwm_o and done_o bit is 0.
- R2: When en_mask_i bit n is first seen high with channel n idle, pwm_o[n] is 1 from the next clock on, with no tick needed.
- R3: With the high setting H and the low setting L, the output stays high for exactly H ticks and then low for exactly L ticks. Levels change only on a clock where tick_i is 1.
- R4: A high or low setting of 0 behaves exactly as a setting of 1.
- R5: With a burst setting B greater than 0, exactly B high pulses are emitted. After the last low interval, pwm_o[n] stays 0 and done_o[n] is 1 for as long as the channel remains enabled.
- R6: A burst setting of 0 repeats high and low intervals without end, and done_o[n] is never raised.
- R7: One clock after en_mask_i bit n goes low, pwm_o[n] and done_o[n] are 0. A later enable restarts with a full high interval.
- R8: Bit n of en_mask_i, pwm_o and done_o belongs to channel n. Channel n's settings occupy bits [16n+15:16n] of hi_div_i, lo_div_i and burst_i. The two channels do not affect each other.
- R9: The settings are captured on the enabling clock. Changes to hi_div_i, lo_div_i or burst_i while the channel is enabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one clock wide per tick |
| en_mask_i | input | 2 | Channel enables, bit n for channel n |
| hi_div_i | input | 32 | High interval in ticks, 16 bits per channel |
| lo_div_i | input | 32 | Low interval in ticks, 16 bits per channel |
| burst_i | input | 32 | Pulse count per channel, 0 means continuous |
| pwm_o | output | 2 | Pulse outputs |
| done_o | output | 2 | Burst complete flags |

## Verification
Every output comes from a channel's state register. pwm_o and done_o therefore change exactly one clock after the edge that samples an enable change or the tick that closes an interval. Nothing moves on the edge where the input first appears. The bench changes the enables, settings and tick on the falling edge. It reads the outputs on the following falling edge, which is half a clock after they settle. The tick count for each level uses the tick that will be consumed at the next rising edge, paired with the level visible just before that edge. The counts of high ticks, low ticks and rising edges therefore follow directly from R3 to R5.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HIGH = 2'd1,
      ST_LOW  = 2'd2,
      ST_DONE = 2'd3
   } bpwm_state_t;

   // A zero-length interval is promoted to one tick
   function automatic logic [15:0] clamp_div16(input logic [15:0] d);
      return (d == 16'd0) ? 16'd1 : d;
   endfunction
endpackage

// File: rtl/bpwm_phase_timer.sv
module bpwm_phase_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [CNT_W-1:0] cnt_q;

   assign last_o = (cnt_q == limit_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (adv_i)
         cnt_q <= last_o ? '0 : cnt_q + 1'b1;
   end

   // R3
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bpwm_channel.sv
module bpwm_channel
   import burst_pwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] hi_i,
   input  logic [CNT_W-1:0] lo_i,
   input  logic [CNT_W-1:0] burst_i,
   output logic             pwm_o,
   output logic             done_o
);
   timeunit 1ns;
   timeprecision 100ps;

   bpwm_state_t      st_q;
   logic [CNT_W-1:0] hi_q, lo_q, burst_q, pulses_q;
   logic             phase_last, running, phase_end;
   logic [CNT_W-1:0] limit;

   assign running   = (st_q == ST_HIGH) || (st_q == ST_LOW);
   assign limit     = (st_q == ST_LOW) ? lo_q : hi_q;
   assign phase_end = running && tick_i && phase_last;

   bpwm_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (!running || !en_i),
      .adv_i   (running && tick_i),
      .limit_i (limit),
      .last_o  (phase_last)
   );

   function automatic logic [CNT_W-1:0] clamp_div(input logic [CNT_W-1:0] d);
      return (d == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : d;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         hi_q     <= {{(CNT_W-1){1'b0}}, 1'b1};
         lo_q     <= {{(CNT_W-1){1'b0}}, 1'b1};
         burst_q  <= '0;
         pulses_q <= '0;
      end else if (!en_i) begin
         st_q     <= ST_IDLE;
         pulses_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               hi_q     <= clamp_div(hi_i);
               lo_q     <= clamp_div(lo_i);
               burst_q  <= burst_i;
               pulses_q <= '0;
               st_q     <= ST_HIGH;
            end
            ST_HIGH: if (phase_end) st_q <= ST_LOW;
            ST_LOW: if (phase_end) begin
               if ((burst_q != '0) && (pulses_q == burst_q - 1'b1))
                  st_q <= ST_DONE;
               else begin
                  st_q     <= ST_HIGH;
                  pulses_q <= pulses_q + 1'b1;
               end
            end
            default: st_q <= ST_DONE;
         endcase
      end
   end

   assign pwm_o  = (st_q == ST_HIGH);
   assign done_o = (st_q == ST_DONE);

   // R2
   start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == ST_IDLE) |=> pwm_o);
   // R3
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && running && !tick_i) |=> ($stable(pwm_o) && $stable(done_o)));
   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && done_o) |=> (done_o && !pwm_o));
   // R7
   disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!pwm_o && !done_o));
endmodule

// File: rtl/burst_pwm_pair.sv
module burst_pwm_pair #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic [NUM_CH-1:0]       en_mask_i,
   input  logic [NUM_CH*CNT_W-1:0] hi_div_i,
   input  logic [NUM_CH*CNT_W-1:0] lo_div_i,
   input  logic [NUM_CH*CNT_W-1:0] burst_i,
   output logic [NUM_CH-1:0]       pwm_o,
   output logic [NUM_CH-1:0]       done_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int BUS_W = NUM_CH * CNT_W;

   if (NUM_CH < 1 || CNT_W < 2 || BUS_W > 1024) begin : g_bad_cfg
      $error("burst_pwm_pair: unsupported NUM_CH/CNT_W");
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      bpwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_i    (en_mask_i[n]),
         .tick_i  (tick_i),
         .hi_i    (hi_div_i[n*CNT_W +: CNT_W]),
         .lo_i    (lo_div_i[n*CNT_W +: CNT_W]),
         .burst_i (burst_i[n*CNT_W +: CNT_W]),
         .pwm_o   (pwm_o[n]),
         .done_o  (done_o[n])
      );
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (pwm_o == '0 && done_o == '0));
endmodule

// File: tb/burst_pwm_pair_tb.sv
module burst_pwm_pair_tb;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  en_mask = 2'b00;
   logic [31:0] hi_div = '0, lo_div = '0, burst = '0;
   logic [1:0]  pwm, done;

   int errors = 0, checks = 0, cyc = 0, period = 1;
   int hi_t[2], lo_t[2], rises[2];
   logic prev[2];

   always #2.5 clk = ~clk;

   burst_pwm_pair u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_mask_i(en_mask),
      .hi_div_i(hi_div), .lo_div_i(lo_div), .burst_i(burst),
      .pwm_o(pwm), .done_o(done)
   );

   // rows: {hi, lo, burst, tick period}
   localparam logic [63:0] VEC [6] = '{
      64'h0001_0001_0001_0001,
      64'h0003_0002_0004_0001,
      64'h0002_0005_0003_0003,
      64'h0000_0000_0002_0001,
      64'h0005_0001_0001_0002,
      64'h0004_0007_0002_0001
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      for (int c = 0; c < 2; c++) begin
         hi_t[c] = 0; lo_t[c] = 0; rises[c] = 0; prev[c] = pwm[c];
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cyc++;
         tick = (period > 0) && (cyc % period == 0);
         for (int c = 0; c < 2; c++) begin
            if (pwm[c] && !prev[c]) rises[c]++;
            if (tick && pwm[c]) hi_t[c]++;
            if (tick && !pwm[c] && !done[c] && en_mask[c]) lo_t[c]++;
            prev[c] = pwm[c];
         end
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int h, l, b, ch;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pwm during reset", pwm, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pwm after reset", pwm, 0);
      check("R1 done after reset", done, 0);

      // vector walk: R3 R4 R5 R8
      for (int i = 0; i < 6; i++) begin
         ch = i % 2;
         h = (VEC[i][63:48] == 0) ? 1 : int'(VEC[i][63:48]);
         l = (VEC[i][47:32] == 0) ? 1 : int'(VEC[i][47:32]);
         b = int'(VEC[i][31:16]);
         period = int'(VEC[i][15:0]);
         @(negedge clk);
         hi_div = '0; lo_div = '0; burst = '0;
         hi_div[16*ch +: 16] = VEC[i][63:48];
         lo_div[16*ch +: 16] = VEC[i][47:32];
         burst[16*ch +: 16]  = VEC[i][31:16];
         en_mask = 2'b00;
         en_mask[ch] = 1'b1;
         tick = 1'b0;
         clear_stats();
         step((h + l) * b * period + 8);
         check($sformatf("R3 R4 high ticks row %0d", i), hi_t[ch], h * b);
         check($sformatf("R3 R4 low ticks row %0d", i), lo_t[ch], l * b);
         check($sformatf("R5 pulses row %0d", i), rises[ch], b);
         check($sformatf("R5 done row %0d", i), done[ch], 1);
         check($sformatf("R5 parked low row %0d", i), pwm[ch], 0);
         check($sformatf("R8 idle channel row %0d", i), rises[1-ch] + done[1-ch], 0);
         en_mask = 2'b00;
         step(1);
         check($sformatf("R7 done cleared row %0d", i), done[ch], 0);
      end

      // R2: start high with no tick, and hold without ticks (R3)
      period = 0;
      hi_div = 32'h0000_0004; lo_div = 32'h0000_0004; burst = 32'h0;
      en_mask = 2'b01;
      step(1);
      check("R2 high right after enable", pwm[0], 1);
      step(6);
      check("R3 no tick keeps high", pwm[0], 1);
      en_mask = 2'b00;
      step(1);

      // R6 continuous burst
      period = 1;
      hi_div = 32'h0000_0002; lo_div = 32'h0000_0003; burst = 32'h0;
      en_mask = 2'b01; tick = 1'b0;
      clear_stats();
      step(100);
      check("R6 continuous pulses", rises[0], 20);
      check("R6 continuous high ticks", hi_t[0], 40);
      check("R6 no done", done[0], 0);
      en_mask = 2'b00;
      step(1);

      // R7 disable mid-high and restart fresh
      hi_div = 32'h0000_000A; lo_div = 32'h0000_000A; burst = 32'h0;
      en_mask = 2'b01;
      step(4);
      en_mask = 2'b00;
      step(1);
      check("R7 low after disable", pwm[0], 0);
      en_mask = 2'b01;
      clear_stats();
      step(20);
      check("R7 restart single pulse", rises[0], 1);
      check("R7 restart full high", hi_t[0], 10);
      en_mask = 2'b00;
      step(1);

      // R9 settings captured at enable
      hi_div = 32'h0000_0003; lo_div = 32'h0000_0002; burst = 32'h0000_0002;
      en_mask = 2'b01;
      clear_stats();
      step(2);
      hi_div = 32'h0000_0007; lo_div = 32'h0000_0007; burst = 32'h0000_0009;
      step(40);
      check("R9 high ticks unchanged", hi_t[0], 6);
      check("R9 pulses unchanged", rises[0], 2);
      check("R9 done", done[0], 1);
      en_mask = 2'b00;
      step(1);

      // R8 both channels at once, field positions
      hi_div = 32'h0002_0001; lo_div = 32'h0002_0001; burst = 32'h0002_0003;
      en_mask = 2'b11;
      clear_stats();
      step(30);
      check("R8 ch0 pulses", rises[0], 3);
      check("R8 ch1 pulses", rises[1], 2);
      check("R8 ch0 high ticks", hi_t[0], 3);
      check("R8 ch1 high ticks", hi_t[1], 4);
      check("R8 both done", done, 3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule